// File: doc/BRIEF.md
# Wait-State Bus Arbiter for DMA

This block lets a DMA controller or a memory-refresh requester take the system bus from a CPU running in maximum mode. In that mode the CPU has no hold-request/hold-acknowledge pins. The arbiter therefore stops the CPU by pulling its READY line low, which inserts wait cycles. It then waits until the CPU status lines show a point where the bus can safely change hands. At that point it grants the bus to the DMA side and raises the address-enable line, so CPU-side address drivers stay off the bus. Every DMA transfer goes through this path, including refresh.

A parameter selects the grant point. The strict variant grants only when the status code is passive (all three status bits high). The relaxed variant also grants when the code is halt (the two low bits high, the top bit ignored). The CPU may miss the READY drop and start its next bus cycle anyway. When that happens, a one-cycle flag reports it so the case can be observed and tested.

Top module: `wait_dma_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `cpu_ready`=1, `bus_aen`=0, `dma_grant`=0, `late_freeze`=0.
- R2: When `cpu_ready` is high and `dma_req` is high at a clock edge, `cpu_ready` is low after that edge.
- R3: `dma_grant` and `bus_aen` rise together, one clock after an edge where `cpu_ready` was already low and the status was qualifying.
- R4: With `HALT_GRANT`=0, only `cpu_status`=3'b111 (passive) qualifies; 3'b011 (halt) leaves the CPU frozen with no grant.
- R5: With `HALT_GRANT`=1, any status whose bits [1:0] are 2'b11 qualifies, including 3'b011.
- R6: Once granted, `bus_aen` and `dma_grant` stay high whatever the status lines do, until `dma_done` is seen.
- R7: `cpu_ready` is low for every cycle in which `bus_aen` is high.
- R8: An edge with `dma_done` high during ownership drops `bus_aen` and `dma_grant` at that edge. `cpu_ready` returns high one clock later.
- R9: `late_freeze` pulses high for one cycle under one condition. The status was passive at the edge that first drove `cpu_ready` low, and in the following cycle the status is no longer passive.
- R10: While frozen, a non-qualifying status (for example 3'b100 or 3'b101) keeps `cpu_ready` low and gives no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_status | input | 3 | CPU status lines, bit 2 down to bit 0 |
| dma_req | input | 1 | Bus request from the DMA or refresh side |
| dma_done | input | 1 | DMA side has finished with the bus |
| cpu_ready | output | 1 | READY to the CPU; low inserts wait cycles |
| bus_aen | output | 1 | Address enable to the bus, high while DMA owns it |
| dma_grant | output | 1 | Bus grant to the DMA controller |
| late_freeze | output | 1 | One-cycle pulse: CPU began a new cycle despite the freeze |

## Verification
The embedded properties check the ordering rules on every cycle:
- a request always drops READY;
- a grant only follows a frozen, qualifying status;
- READY never comes back while address enable is high;
- address enable falls only on a done, and READY returns one clock later;
- the late flag only appears during a freeze.

Only the bench scenarios can show the difference between the two variants, because that needs halt and passive codes applied to both builds side by side. The same holds for the exact cycle of the late-freeze pulse and for ownership surviving arbitrary status codes.

// File: rtl/wdma_pkg.sv
// Shared definitions for the wait-state DMA arbiter.
// Assumes a three-bit CPU status bus where all-ones means passive.
package wdma_pkg;
    localparam int STATUS_W = 3;
    localparam logic [STATUS_W-1:0] ST_PASSIVE = 3'b111;

    typedef enum logic [1:0] {
        OWN_CPU     = 2'd0,   // CPU runs, READY high
        OWN_FREEZE  = 2'd1,   // READY low, waiting for a safe status
        OWN_DMA     = 2'd2,   // DMA side owns the bus
        OWN_RETURN  = 2'd3    // AEN dropped, READY released next
    } owner_e;
endpackage

// File: rtl/cpu_status_qualifier.sv
// Decides whether the current CPU status code is a point where the bus
// may be handed over. HALT_GRANT selects the variant: 0 accepts only the
// passive code, 1 also accepts any code with the two low bits set (halt).
// Assumes the status lines are already synchronous to clk.
module cpu_status_qualifier
    import wdma_pkg::*;
#(
    parameter bit HALT_GRANT = 1'b0
) (
    input  logic [STATUS_W-1:0] status,
    output logic                qualifies,
    output logic                passive
);
    // Passive detection is shared by both variants.
    always_comb passive = (status == ST_PASSIVE);

    generate
        if (HALT_GRANT) begin : g_halt_ok
            // Relaxed variant: top bit is ignored.
            always_comb qualifies = &status[1:0];
        end else begin : g_passive_only
            // Strict variant: only the passive code.
            always_comb qualifies = passive;
        end
    endgenerate
endmodule

// File: rtl/bus_owner_fsm.sv
// Four-state ownership sequencer. A request freezes the CPU by dropping
// READY. A qualifying status seen while frozen hands the bus to DMA. A
// done signal drops AEN first and releases READY one clock later.
// Assumes dma_done is only meaningful during ownership.
module bus_owner_fsm
    import wdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_req,
    input  logic dma_done,
    input  logic qualifies,
    output logic cpu_ready,
    output logic bus_aen,
    output logic dma_grant,
    output logic freeze_start,
    output logic frozen
);
    owner_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_CPU:    if (dma_req)   state_d = OWN_FREEZE;
            OWN_FREEZE: if (qualifies) state_d = OWN_DMA;
            OWN_DMA:    if (dma_done)  state_d = OWN_RETURN;
            OWN_RETURN:                state_d = OWN_CPU;
            default:                   state_d = OWN_CPU;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_CPU;
        else        state_q <= state_d;
    end

    // Outputs decoded straight from the registered state.
    always_comb begin
        cpu_ready    = (state_q == OWN_CPU);
        bus_aen      = (state_q == OWN_DMA);
        dma_grant    = (state_q == OWN_DMA);
        frozen       = (state_q == OWN_FREEZE);
        freeze_start = (state_q == OWN_CPU) && dma_req;
    end

    assert_req_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && dma_req) |=> !cpu_ready);

    assert_grant_after_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_grant) |-> $past(!cpu_ready && qualifies));

    assert_aen_blocks_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aen |-> !cpu_ready);

    assert_aen_fall_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_aen) |-> ($past(dma_done) && !cpu_ready));

    assert_ready_after_aen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_aen) |=> cpu_ready);
endmodule

// File: rtl/freeze_slip_detector.sv
// Flags the case where READY was pulled low too late. The status was
// passive at the edge that began the freeze, yet in the first frozen
// cycle the CPU has already moved to a new bus-cycle code. The output is
// a registered single-cycle pulse.
module freeze_slip_detector
    import wdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic passive,
    input  logic freeze_start,
    input  logic frozen,
    output logic late_freeze
);
    logic passive_q;
    logic fresh_q;

    // Remember the status class and whether this is the first frozen cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            passive_q <= 1'b0;
            fresh_q   <= 1'b0;
        end else begin
            passive_q <= passive;
            fresh_q   <= freeze_start;
        end
    end

    // Raise the flag for one cycle when the CPU slipped past the freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) late_freeze <= 1'b0;
        else        late_freeze <= frozen && fresh_q && passive_q && !passive;
    end

    assert_slip_only_when_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        late_freeze |-> $past(frozen));

    assert_slip_is_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        late_freeze |=> !late_freeze);
endmodule

// File: rtl/wait_dma_arbiter.sv
// Top level: gives the bus to a DMA or refresh requester by freezing a
// maximum-mode CPU through READY instead of a hold handshake.
// HALT_GRANT=0 grants at passive only; 1 also grants at halt.
// Assumes all inputs are synchronous to clk.
module wait_dma_arbiter
    import wdma_pkg::*;
#(
    parameter bit HALT_GRANT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] cpu_status,
    input  logic                dma_req,
    input  logic                dma_done,
    output logic                cpu_ready,
    output logic                bus_aen,
    output logic                dma_grant,
    output logic                late_freeze
);
    logic qualifies;
    logic passive;
    logic freeze_start;
    logic frozen;

    cpu_status_qualifier #(.HALT_GRANT(HALT_GRANT)) u_qual (
        .status    (cpu_status),
        .qualifies (qualifies),
        .passive   (passive)
    );

    bus_owner_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dma_req      (dma_req),
        .dma_done     (dma_done),
        .qualifies    (qualifies),
        .cpu_ready    (cpu_ready),
        .bus_aen      (bus_aen),
        .dma_grant    (dma_grant),
        .freeze_start (freeze_start),
        .frozen       (frozen)
    );

    freeze_slip_detector u_slip (
        .clk          (clk),
        .rst_n        (rst_n),
        .passive      (passive),
        .freeze_start (freeze_start),
        .frozen       (frozen),
        .late_freeze  (late_freeze)
    );

    assert_grant_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_grant && !dma_done) |=> dma_grant);
endmodule

// File: tb/tb_wait_dma_arbiter.sv
// Scoreboard bench: the driver pushes the expected outputs of both
// variants per step, and a monitor pops and compares them at the falling edge.
module tb_wait_dma_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_status = 3'b111;
    logic       dma_req = 1'b0;
    logic       dma_done = 1'b0;

    logic ra, aa, ga, la;
    logic rb, ab, gb, lb;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0] exp_a;   // {ready, aen, grant, late} strict variant
        logic [3:0] exp_b;   // same, halt-granting variant
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;    // 250 MHz

    wait_dma_arbiter #(.HALT_GRANT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_status(cpu_status), .dma_req(dma_req),
        .dma_done(dma_done), .cpu_ready(ra), .bus_aen(aa), .dma_grant(ga),
        .late_freeze(la));

    wait_dma_arbiter #(.HALT_GRANT(1'b1)) dut_halt (
        .clk(clk), .rst_n(rst_n), .cpu_status(cpu_status), .dma_req(dma_req),
        .dma_done(dma_done), .cpu_ready(rb), .bus_aen(ab), .dma_grant(gb),
        .late_freeze(lb));

    // Monitor: compare the oldest expectation with both instances.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if ({ra, aa, ga, la} !== it.exp_a) begin
                fails++;
                $display("FAIL %s strict: got %b expected %b", it.tag, {ra, aa, ga, la}, it.exp_a);
            end
            checks++;
            if ({rb, ab, gb, lb} !== it.exp_b) begin
                fails++;
                $display("FAIL %s halt: got %b expected %b", it.tag, {rb, ab, gb, lb}, it.exp_b);
            end
        end
    end

    // Driver: apply inputs for one clock and queue the result expected after it.
    task automatic step(input logic req, input logic done, input logic [2:0] st,
                        input logic [3:0] ea, input logic [3:0] eb, input string tag);
        item_t it;
        @(negedge clk);
        dma_req = req;
        dma_done = done;
        cpu_status = st;
        @(posedge clk);
        #1;
        it.exp_a = ea;
        it.exp_b = eb;
        it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, 3'b111, 4'b1000, 4'b1000, "R1");
        step(1'b0, 1'b0, 3'b111, 4'b1000, 4'b1000, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Halt code: strict waits, relaxed grants (R4, R5)
        step(1'b1, 1'b0, 3'b011, 4'b0000, 4'b0000, "R2");
        step(1'b1, 1'b0, 3'b011, 4'b0000, 4'b0110, "R4/R5 halt");
        step(1'b1, 1'b0, 3'b011, 4'b0000, 4'b0110, "R4");
        step(1'b1, 1'b0, 3'b111, 4'b0110, 4'b0110, "R3 passive grant");
        step(1'b0, 1'b0, 3'b000, 4'b0110, 4'b0110, "R6 status ignored");
        step(1'b0, 1'b0, 3'b100, 4'b0110, 4'b0110, "R6 status ignored");
        step(1'b0, 1'b1, 3'b111, 4'b0000, 4'b0000, "R8 aen drop");
        step(1'b0, 1'b0, 3'b111, 4'b1000, 4'b1000, "R8 ready back");
        step(1'b0, 1'b0, 3'b111, 4'b1000, 4'b1000, "R8 idle");

        // Late freeze: passive at request edge, new code next cycle (R9)
        step(1'b1, 1'b0, 3'b111, 4'b0000, 4'b0000, "R2");
        step(1'b1, 1'b0, 3'b100, 4'b0001, 4'b0001, "R9 slip");
        step(1'b1, 1'b0, 3'b101, 4'b0000, 4'b0000, "R10 no grant");
        step(1'b1, 1'b0, 3'b100, 4'b0000, 4'b0000, "R10 no grant");
        step(1'b1, 1'b0, 3'b111, 4'b0110, 4'b0110, "R3");
        step(1'b0, 1'b1, 3'b111, 4'b0000, 4'b0000, "R8");
        step(1'b0, 1'b0, 3'b111, 4'b1000, 4'b1000, "R8");

        // Passive held: grant without a slip flag (R9 negative, R7)
        step(1'b1, 1'b0, 3'b111, 4'b0000, 4'b0000, "R2");
        step(1'b0, 1'b0, 3'b111, 4'b0110, 4'b0110, "R7 no slip");
        step(1'b0, 1'b1, 3'b010, 4'b0000, 4'b0000, "R8");
        step(1'b0, 1'b0, 3'b010, 4'b1000, 4'b1000, "R8");

        // Wait for the monitor to drain the queue.
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #80000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule